// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a small serial EEPROM that hangs on an open-drain two-wire bus. It watches the clock and data lines with its own system clock, and it finds start and stop conditions and the data bits in what it sees. It answers only to a device address that carries a fixed prefix and a strap field that fits its configured variant. It pulls the data line low to acknowledge and to send zero bits. It never drives the line high.

A write sends the device address, then one word-address byte, then any number of data bytes. The data bytes collect in a page buffer, and the low address bits wrap inside the page. A stop condition after at least one data byte starts an internal write cycle, and the page is stored when that cycle ends. While the cycle runs, the block does not answer its device address, so a master can poll for completion. A read sends bytes starting at the current pointer and keeps going as long as the master acknowledges each one.

Top module: `eeprom2w_slave`

## Requirements
- R1: A device address byte is accepted only if bits 7:4 equal 1010 and bits 3:1 (A2, A1, A0) equal `strap_i[2:0]` on the compared positions. The positions compared depend on VARIANT: 0 compares all three, 1 compares A2 and A1, 2 compares A2 only, 3 compares none. Bit 0 is 0 for a write and 1 for a read. After a rejected address the block leaves the line alone until the next start.
- R2: After an accepted device address, and after every byte received in a write, the block holds SDA low through the ninth clock.
- R3: A stop that starts a write cycle makes the block busy for WCYC_CLKS clocks. During that time a device address that would otherwise match gets no acknowledge.
- R4: In a write, the first byte after the device address sets the 8-bit word pointer. Each later byte goes to the page slot given by the pointer's low log2(PAGE_BYTES) bits. Those low bits then advance and wrap inside the page, and the upper bits do not change.
- R5: The buffered page reaches the memory only when the write cycle ends. A stop after the word address alone, with no data byte, sets the pointer and starts no write cycle.
- R6: A read sends the byte at the pointer, most significant bit first, and then advances the pointer. The pointer wraps from 255 to 0. The read continues while the master acknowledges. When the master does not acknowledge, the block stops driving.
- R7: A stop releases SDA and ends the transfer at any point, including in the middle of a byte. A start, whether first or repeated, restarts device-address reception and discards page data that has not yet been committed.
- R8: After reset every memory byte and the pointer are zero and SDA is released.
- R9: SDA is pulled low only in an acknowledge slot or while a read byte is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | When 1, the open-drain driver pulls SDA low |
| strap_i | input | 3 | Address straps {A2, A1, A0} |

## Verification
Two events can fall on the same system clock: the write-cycle timer expiring, which stores the page and clears busy, and the acknowledge decision for a device address sent during acknowledge polling. The bench writes a page and then polls with device addresses until one is acknowledged. The poll cannot be placed with cycle precision, so the boundary cycle itself is not guaranteed to be hit. The bench requires at least one refused poll and then an acknowledge within a bounded number of polls. It then reads the page back at once: an acknowledged poll must never show old data, so the store has to take place no later than the release of busy.

// File: rtl/eep_pkg.sv
// Package: shared constants, state encoding and strap-mask helper for the
// two-wire EEPROM slave. Assumes a word address of one byte.
package eep_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;
    localparam int         WORD_W     = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RD_MACK
    } eep_state_t;

    // Which of {A2,A1,A0} a variant compares.
    function automatic logic [2:0] strap_mask(input int variant);
        case (variant)
            0:       return 3'b111;
            1:       return 3'b110;
            2:       return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/eep_bus_sense.sv
// Bus sensing: synchronises SCL/SDA into the clk domain and flags clock
// edges plus start/stop conditions. Assumes the bus is much slower than clk
// and that SYNC_STAGES >= 2.
module eep_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);

    logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
    logic                   scl_d, sda_d, scl_s;

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_sr[SYNC_STAGES-1];
            sda_d  <= sda_sr[SYNC_STAGES-1];
        end
    end

    // Edge and condition decode.
    always_comb begin
        scl_s     = scl_sr[SYNC_STAGES-1];
        sda_s     = sda_sr[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/eep_addr_match.sv
// Device-address compare: checks the fixed prefix and the strap bits that
// the chosen VARIANT uses; other strap positions are don't-care.
module eep_addr_match
    import eep_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic [6:0] dev_hi,   // device byte bits 7:1
    input  logic [2:0] strap,
    output logic       hit
);

    localparam logic [2:0] MASK = strap_mask(VARIANT);

    logic [2:0] bit_ok;

    genvar gi;
    generate
        for (gi = 0; gi < 3; gi++) begin : g_cmp
            if (MASK[gi]) begin : g_used
                assign bit_ok[gi] = (dev_hi[gi] == strap[gi]);
            end else begin : g_free
                assign bit_ok[gi] = 1'b1;
            end
        end
    endgenerate

    // Prefix plus compared strap bits.
    always_comb hit = (dev_hi[6:3] == DEV_PREFIX) && (&bit_ok);

endmodule

// File: rtl/eep_wr_timer.sv
// Write-cycle timer: a kick loads CYCLES, busy stays high while counting,
// expire pulses in the final busy clock. Assumes CYCLES >= 2.
module eep_wr_timer #(
    parameter int CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy,
    output logic expire
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    // Down-counter for the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (kick)       cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Status decode.
    always_comb begin
        busy   = (cnt != '0);
        expire = (cnt == CW'(1));
    end

    // R3
    kick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> !busy);

    // R5
    expire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !busy);

endmodule

// File: rtl/eeprom2w_slave.sv
// Top: two-wire EEPROM slave with 256-byte storage, page buffer and a
// write-cycle timer. Assumes scl_i/sda_i are the wired bus levels and that
// PAGE_BYTES is a power of two between 2 and 128.
module eeprom2w_slave
    import eep_pkg::*;
#(
    parameter int VARIANT    = 0,
    parameter int PAGE_BYTES = 16,
    parameter int WCYC_CLKS  = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] strap_i
);

    localparam int PW    = $clog2(PAGE_BYTES);
    localparam int PB    = WORD_W - PW;
    localparam int DEPTH = 2 ** WORD_W;

    logic scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic hit, wr_busy, wr_expire, wr_kick;

    eep_state_t          state;
    logic [3:0]          bitcnt, txcnt;
    logic [7:0]          shreg, txreg;
    logic [WORD_W-1:0]   ptr_q;
    logic                rw_q, mack_q, pend_q;
    logic [PB-1:0]       cbase_q;
    logic [7:0]          pbuf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;
    logic [7:0]          mem_q  [DEPTH];

    eep_bus_sense #(.SYNC_STAGES(2)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
    );

    eep_addr_match #(.VARIANT(VARIANT)) u_match (
        .dev_hi(shreg[7:1]), .strap(strap_i), .hit(hit)
    );

    eep_wr_timer #(.CYCLES(WCYC_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .kick(wr_kick),
        .busy(wr_busy), .expire(wr_expire)
    );

    // A stop with buffered data starts the write cycle.
    always_comb wr_kick = stop_det & pend_q;

    // Bus protocol engine: bit/byte sequencing, acknowledge and read drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            txcnt      <= '0;
            shreg      <= '0;
            txreg      <= '0;
            ptr_q      <= '0;
            rw_q       <= 1'b0;
            mack_q     <= 1'b0;
            pend_q     <= 1'b0;
            cbase_q    <= '0;
            vld_q      <= '0;
            sda_pull_o <= 1'b0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= '0;
        end else begin
            if (wr_expire) vld_q <= '0;
            if (stop_det) begin
                state      <= ST_IDLE;
                sda_pull_o <= 1'b0;
                pend_q     <= 1'b0;
                if (pend_q) cbase_q <= ptr_q[WORD_W-1:PW];
            end else if (start_det) begin
                state      <= ST_DEV;
                bitcnt     <= '0;
                sda_pull_o <= 1'b0;
                pend_q     <= 1'b0;
                if (pend_q) vld_q <= '0;
            end else begin
                if (scl_rise && (state == ST_DEV || state == ST_WADR || state == ST_WDAT)) begin
                    shreg  <= {shreg[6:0], sda_s};
                    bitcnt <= bitcnt + 1'b1;
                end
                case (state)
                    ST_DEV: if (scl_fall && bitcnt == 4'd8) begin
                        if (hit && !wr_busy) begin
                            sda_pull_o <= 1'b1;
                            rw_q       <= shreg[0];
                            state      <= ST_DEV_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_DEV_ACK: if (scl_fall) begin
                        if (rw_q) begin
                            txreg      <= mem_q[ptr_q];
                            sda_pull_o <= ~mem_q[ptr_q][7];
                            txcnt      <= 4'd1;
                            state      <= ST_RDAT;
                        end else begin
                            sda_pull_o <= 1'b0;
                            bitcnt     <= '0;
                            state      <= ST_WADR;
                        end
                    end
                    ST_WADR: if (scl_fall && bitcnt == 4'd8) begin
                        ptr_q      <= shreg;
                        sda_pull_o <= 1'b1;
                        state      <= ST_WADR_ACK;
                    end
                    ST_WADR_ACK, ST_WDAT_ACK: if (scl_fall) begin
                        sda_pull_o <= 1'b0;
                        bitcnt     <= '0;
                        state      <= ST_WDAT;
                    end
                    ST_WDAT: if (scl_fall && bitcnt == 4'd8) begin
                        pbuf_q[ptr_q[PW-1:0]] <= shreg;
                        vld_q[ptr_q[PW-1:0]]  <= 1'b1;
                        ptr_q      <= {ptr_q[WORD_W-1:PW], ptr_q[PW-1:0] + 1'b1};
                        pend_q     <= 1'b1;
                        sda_pull_o <= 1'b1;
                        state      <= ST_WDAT_ACK;
                    end
                    ST_RDAT: if (scl_fall) begin
                        if (txcnt == 4'd8) begin
                            sda_pull_o <= 1'b0;
                            ptr_q      <= ptr_q + 1'b1;
                            state      <= ST_RD_MACK;
                        end else begin
                            sda_pull_o <= ~txreg[6];
                            txreg      <= {txreg[6:0], 1'b0};
                            txcnt      <= txcnt + 1'b1;
                        end
                    end
                    ST_RD_MACK: begin
                        if (scl_rise) mack_q <= ~sda_s;
                        if (scl_fall) begin
                            if (mack_q) begin
                                txreg      <= mem_q[ptr_q];
                                sda_pull_o <= ~mem_q[ptr_q][7];
                                txcnt      <= 4'd1;
                                state      <= ST_RDAT;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Storage array: cleared on reset, page committed at timer expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_expire) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (vld_q[i]) mem_q[{cbase_q, PW'(i)}] <= pbuf_q[i];
        end
    end

    // R9
    pull_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> (state inside {ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK, ST_RDAT}));

    // R3
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && scl_fall && bitcnt == 4'd8 && wr_busy)
        |=> (state == ST_IDLE && !sda_pull_o));

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_pull_o));

    // R5
    commit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_expire |-> !(state inside {ST_WADR, ST_WADR_ACK, ST_WDAT, ST_WDAT_ACK}));

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDAT_ACK && $past(state) == ST_WDAT)
        |-> ptr_q[WORD_W-1:PW] == $past(ptr_q[WORD_W-1:PW]));

endmodule

// File: tb/eeprom2w_slave_bench.sv
// Bench: bit-banged bus master, reference memory model, directed corners
// and seeded random page writes with read-back.
module eeprom2w_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;      // quarter bus bit, in clk cycles
    localparam int PAGE       = 16;
    localparam int WCYC       = 500;
    localparam logic [2:0] STRAP = 3'b110;
    localparam logic [7:0] DEV_W = 8'hAC;  // 1010 110 0
    localparam logic [7:0] DEV_R = 8'hAD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;
    int   checks = 0, errors = 0;
    logic done = 1'b0;
    logic [7:0] ref_mem [256];
    int   ref_ptr = 0;
    logic [7:0] wbuf [32];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    eeprom2w_slave #(.VARIANT(1), .PAGE_BYTES(PAGE), .WCYC_CLKS(WCYC)) u_eeprom2w_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .strap_i(STRAP)
    );

    function automatic int page_slot(input int base, input int k);
        return (base & ~(PAGE-1)) | ((base + k) & (PAGE-1));
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
        s = sda_line; tick(Q); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            d[i] = s;
        end
        clock_bit(~give_ack, s);
    endtask

    // Acknowledge polling; returns the number of refused polls.
    task automatic wait_ready(output int refused);
        logic ack;
        refused = 0;
        for (int p = 0; p < 12; p++) begin
            bus_start(); wr_byte(DEV_W, ack); bus_stop();
            if (ack) break;
            refused++;
        end
    endtask

    task automatic page_write(input int addr, input int n, input logic poll_check);
        logic ack;
        int   refused;
        bus_start();
        wr_byte(DEV_W, ack);          chk("R2", "devaddr ack", ack, 1);
        wr_byte(8'(addr), ack);       chk("R2", "word addr ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            wr_byte(wbuf[k], ack);
            if (!ack) chk("R2", "data ack", ack, 1);
            ref_mem[page_slot(addr, k)] = wbuf[k];
        end
        bus_stop();
        ref_ptr = page_slot(addr, n);
        if (poll_check) begin
            bus_start(); wr_byte(DEV_W, ack); bus_stop();
            chk("R3", "nack while busy", ack, 0);
        end
        wait_ready(refused);
        chk("R3", "poll finally acked", int'(refused < 12), 1);
    endtask

    task automatic seq_read(input int addr, input int n, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        wr_byte(DEV_W, ack);    chk(req, "rd devaddr ack", ack, 1);
        wr_byte(8'(addr), ack); chk(req, "rd word addr ack", ack, 1);
        bus_start();
        wr_byte(DEV_R, ack);    chk(req, "rd dev read ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k != n-1, d);
            chk(req, $sformatf("read byte @%0h", (addr + k) & 255), d, ref_mem[(addr + k) & 255]);
        end
        bus_stop();
        ref_ptr = (addr + n) & 255;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        logic ack, s;
        logic [7:0] d;
        int   refused, seed, a, n;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        tick(5); rst_n = 1'b1; tick(5);

        // R8: reset state
        chk("R8", "pull released after reset", sda_pull, 0);
        bus_start(); wr_byte(DEV_R, ack); chk("R1", "read address ack", ack, 1);
        rd_byte(1'b0, d); bus_stop();
        chk("R8", "mem[0] after reset", d, 0);
        chk("R6", "released after nack", sda_pull, 0);
        ref_ptr = 1;

        // R1: strap compare, variant 1 (A0 ignored)
        bus_start(); wr_byte(8'hAE, ack); bus_stop(); chk("R1", "A0 don't-care", ack, 1);
        bus_start(); wr_byte(8'hA8, ack); bus_stop(); chk("R1", "A1 mismatch", ack, 0);
        bus_start(); wr_byte(8'hA4, ack); bus_stop(); chk("R1", "A2 mismatch", ack, 0);
        bus_start(); wr_byte(8'hBC, ack); bus_stop(); chk("R1", "prefix mismatch", ack, 0);
        chk("R1", "rejected leaves line", sda_pull, 0);

        // R4/R5/R3: page wrap write, busy nack, commit then read
        for (int k = 0; k < 6; k++) wbuf[k] = 8'(8'h31 + k * 7);
        page_write(8'h1C, 6, 1'b1);
        seq_read(8'h10, 16, "R4");

        // R5: address-only write starts no cycle, sets pointer
        ref_mem[8'h41] = 8'h00;
        bus_start(); wr_byte(DEV_W, ack); wr_byte(8'h40, ack); bus_stop();
        bus_start(); wr_byte(DEV_R, ack);
        chk("R5", "no busy after address-only", ack, 1);
        rd_byte(1'b1, d); chk("R5", "current read @40", d, 0);
        rd_byte(1'b0, d); chk("R6", "current read @41", d, 0);
        bus_stop();

        // R7: repeated start discards page data
        bus_start(); wr_byte(DEV_W, ack); wr_byte(8'h50, ack); wr_byte(8'hA5, ack);
        bus_start(); wr_byte(DEV_W, ack);
        chk("R7", "restart then ack (no cycle)", ack, 1);
        bus_stop();
        seq_read(8'h50, 1, "R7");

        // R7: stop in the middle of a data byte
        bus_start(); wr_byte(DEV_W, ack); wr_byte(8'h60, ack);
        for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
        bus_stop();
        chk("R7", "stop mid-byte releases", sda_pull, 0);
        bus_start(); wr_byte(DEV_W, ack); bus_stop();
        chk("R7", "no cycle after aborted byte", ack, 1);
        seq_read(8'h60, 1, "R7");

        // R6: pointer wraps at the end of memory
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        page_write(8'hFE, 2, 1'b1);
        seq_read(8'hFE, 4, "R6");

        // Random page writes with read-back
        for (int it = 0; it < 6; it++) begin
            a = int'($urandom % 256);
            n = 1 + int'($urandom % 20);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            page_write(a, n, it[0]);
            seq_read(a & ~(PAGE-1), PAGE, "R4");
        end

        done = 1'b1;
        report();
    end

endmodule